// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Codec

This block holds a registered Hamming encoder and a registered Hamming decoder that share one parity-group unit. The encoder takes a data word with a valid strobe. One clock later it presents a codeword in which the check bits are interleaved with the data. Check bits sit at the 1-based positions that are powers of two, and data bits fill the other positions in ascending order. The decoder takes a received codeword and recomputes every parity group. One clock later it presents the syndrome, the data with any single flipped bit repaired, and a flag that shows a correction was made.

The data width is a parameter. It must produce a perfect code, so the codeword length equals 2^p - 1 for p check bits. The default width of 11 gives the (15,11) code. A width of 4 gives the (7,4) code, which has short vectors that can be checked by hand. A syndrome read as a binary number is the 1-based position of the flipped bit.

Top module: `hamming_codec`

## Requirements
- R1: Code bit i (0-based) carries position i+1. Check bits occupy positions 1, 2, 4 and 8, up to the code length. Data bit k (bit 0 is the first data bit) goes to the k-th non-power-of-two position in ascending order. For the (15,11) code, data 0x001 encodes to 0x0007 and data 0x400 encodes to 0x408B.
- R2: Check bit 2^j is the XOR of the data bits at every position whose binary index has bit j set. Each such group, including its check bit, therefore has even parity.
- R3: When `enc_valid_i` is sampled high, `enc_valid_o` is high in the next cycle and `enc_code_o` holds that word's codeword. When `enc_valid_i` is low, `enc_valid_o` is low in the next cycle and `enc_code_o` keeps its value.
- R4: Syndrome bit j is the XOR of all received bits whose position has bit j set. For a codeword with one flipped bit, the syndrome equals that bit's position. For an intact codeword it is zero.
- R5: When a single flip lands on a data position, `dec_data_o` returns the original data and `dec_fixed_o` is 1.
- R6: A zero syndrome passes the data through unchanged, with `dec_fixed_o` at 0.
- R7: A syndrome that names a check-bit position sets `dec_fixed_o` and leaves the data unchanged.
- R8: When `dec_valid_i` is sampled high, `dec_valid_o` is high in the next cycle with that word's results. When `dec_valid_i` is low, `dec_valid_o` is low in the next cycle and all decoder outputs hold.
- R9: A synchronous active-high `rst` clears every output to zero.
- R10: With the data width set to 4, the data bits 0,0,1,0 (first bit first) encode to the position 1..7 sequence 0,1,0,1,0,1,0 (code 0x2A). The received sequence 1,0,1,0,1,1,1 (code 0x75) gives syndrome 6 and the data bits 1,1,0,1 (value 0xB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_valid_i | input | 1 | Encoder input strobe |
| enc_data_i | input | DATA_W | Data word to encode |
| enc_valid_o | output | 1 | Encoder result strobe |
| enc_code_o | output | CODE_W | Interleaved codeword |
| dec_valid_i | input | 1 | Decoder input strobe |
| dec_code_i | input | CODE_W | Received codeword |
| dec_valid_o | output | 1 | Decoder result strobe |
| dec_data_o | output | DATA_W | Corrected data |
| dec_syn_o | output | PAR_W | Syndrome (position of the flipped bit) |
| dec_fixed_o | output | 1 | A bit was inverted (syndrome non-zero) |

## Verification
A wrong group mask in the shared parity unit shows up one cycle after the first affected word. The codeword leaves the encoder with a bad check bit, and clean words reach the decoder with a non-zero syndrome and a spurious correction flag. A wrong data-slot mapping shows at once as data that does not round-trip, even with no injected flip. A stuck valid or a missing hold enable shows on the next cycle as a strobe out of step with the input, or as outputs that move while idle. Every data position and every check position is flipped in turn, so an error in the correction comparator shows as the wrong bit being repaired.

// File: rtl/hamming_pkg.sv
package hamming_pkg;

   // smallest check-bit count p with 2^p >= p + d + 1
   function automatic int par_width(input int d);
      int p;
      p = 1;
      while ((1 << p) < (p + d + 1)) p++;
      return p;
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // data index held at a non-power-of-two 1-based position
   function automatic int data_index(input int pos);
      return pos - $clog2(pos + 1) - 1;
   endfunction

   // positions (1-based, stored at bit pos-1) covered by group j
   function automatic logic [63:0] cover_mask(input int j);
      logic [63:0] m;
      m = '0;
      for (int i = 1; i <= 63; i++)
         if (((i >> j) & 1) == 1) m[i-1] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/ham_syndrome.sv
module ham_syndrome #(
   parameter int CODE_W = 15,
   parameter int PAR_W  = 4
) (
   input  logic [CODE_W-1:0] word_i,
   output logic [PAR_W-1:0]  syn_o
);
   for (genvar j = 0; j < PAR_W; j++) begin : g_grp
      localparam logic [63:0] FULL = hamming_pkg::cover_mask(j);
      localparam logic [CODE_W-1:0] MASK = FULL[CODE_W-1:0];
      assign syn_o[j] = ^(word_i & MASK);
   end
endmodule

// File: rtl/ham_encoder.sv
module ham_encoder #(
   parameter int DATA_W = 11,
   parameter int PAR_W  = 4,
   parameter int CODE_W = 15
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              valid_o,
   output logic [CODE_W-1:0] code_o
);
   logic [CODE_W-1:0] placed;
   logic [CODE_W-1:0] code_c;
   logic [PAR_W-1:0]  par;

   for (genvar i = 1; i <= CODE_W; i++) begin : g_pos
      if (hamming_pkg::is_pow2(i)) begin : g_chk
         assign placed[i-1] = 1'b0;
         assign code_c[i-1] = par[$clog2(i)];
      end else begin : g_dat
         assign placed[i-1] = data_i[hamming_pkg::data_index(i)];
         assign code_c[i-1] = placed[i-1];
      end
   end

   // with zeroed check slots, the group XOR is the needed check bit
   ham_syndrome #(.CODE_W(CODE_W), .PAR_W(PAR_W)) u_par (
      .word_i (placed),
      .syn_o  (par)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_o <= 1'b0;
         code_o  <= '0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) code_o <= code_c;
      end
   end
endmodule

// File: rtl/ham_decoder.sv
module ham_decoder #(
   parameter int DATA_W = 11,
   parameter int PAR_W  = 4,
   parameter int CODE_W = 15
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o,
   output logic [PAR_W-1:0]  syn_o,
   output logic              fixed_o
);
   logic [PAR_W-1:0]  syn_c;
   logic [DATA_W-1:0] data_c;

   ham_syndrome #(.CODE_W(CODE_W), .PAR_W(PAR_W)) u_syn (
      .word_i (code_i),
      .syn_o  (syn_c)
   );

   // only data slots are repaired; a check-slot hit leaves data intact
   for (genvar i = 1; i <= CODE_W; i++) begin : g_pos
      if (!hamming_pkg::is_pow2(i)) begin : g_dat
         assign data_c[hamming_pkg::data_index(i)] =
            code_i[i-1] ^ (syn_c == PAR_W'(i));
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_o <= 1'b0;
         data_o  <= '0;
         syn_o   <= '0;
         fixed_o <= 1'b0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) begin
            data_o  <= data_c;
            syn_o   <= syn_c;
            fixed_o <= |syn_c;
         end
      end
   end
endmodule

// File: rtl/hamming_codec.sv
module hamming_codec #(
   parameter int DATA_W = 11,
   localparam int PAR_W  = hamming_pkg::par_width(DATA_W),
   localparam int CODE_W = DATA_W + PAR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enc_valid_i,
   input  logic [DATA_W-1:0] enc_data_i,
   output logic              enc_valid_o,
   output logic [CODE_W-1:0] enc_code_o,
   input  logic              dec_valid_i,
   input  logic [CODE_W-1:0] dec_code_i,
   output logic              dec_valid_o,
   output logic [DATA_W-1:0] dec_data_o,
   output logic [PAR_W-1:0]  dec_syn_o,
   output logic              dec_fixed_o
);
   // only perfect codes (length 2^p - 1) up to the 64-bit mask limit
   if (CODE_W != (1 << PAR_W) - 1) begin : g_bad_len
      $error("hamming_codec: DATA_W must yield a perfect code");
   end
   if (CODE_W > 63) begin : g_bad_big
      $error("hamming_codec: code length above 63");
   end

   ham_encoder #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CODE_W(CODE_W)) u_enc (
      .clk     (clk),
      .rst     (rst),
      .valid_i (enc_valid_i),
      .data_i  (enc_data_i),
      .valid_o (enc_valid_o),
      .code_o  (enc_code_o)
   );

   ham_decoder #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CODE_W(CODE_W)) u_dec (
      .clk     (clk),
      .rst     (rst),
      .valid_i (dec_valid_i),
      .code_i  (dec_code_i),
      .valid_o (dec_valid_o),
      .data_o  (dec_data_o),
      .syn_o   (dec_syn_o),
      .fixed_o (dec_fixed_o)
   );
endmodule

// File: rtl/hamming_codec_chk.sv
module hamming_codec_chk #(
   parameter int DATA_W = 11,
   parameter int PAR_W  = 4,
   parameter int CODE_W = 15
) (
   input logic              clk,
   input logic              rst,
   input logic              enc_valid_i,
   input logic              enc_valid_o,
   input logic [CODE_W-1:0] enc_code_o,
   input logic              dec_valid_i,
   input logic              dec_valid_o,
   input logic [DATA_W-1:0] dec_data_o,
   input logic [PAR_W-1:0]  dec_syn_o,
   input logic              dec_fixed_o
);
   a_r3_enc_strobe: assert property (@(posedge clk) disable iff (rst)
      enc_valid_i |=> enc_valid_o);

   a_r3_enc_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !enc_valid_i |=> (!enc_valid_o && $stable(enc_code_o)));

   a_r8_dec_strobe: assert property (@(posedge clk) disable iff (rst)
      dec_valid_i |=> dec_valid_o);

   a_r8_dec_idle_hold: assert property (@(posedge clk) disable iff (rst)
      !dec_valid_i |=> (!dec_valid_o && $stable(dec_data_o)
                        && $stable(dec_syn_o) && $stable(dec_fixed_o)));

   // R6 / R7: flag tracks a non-zero syndrome
   a_r6_flag_vs_syndrome: assert property (@(posedge clk) disable iff (rst)
      dec_valid_o |-> (dec_fixed_o == (dec_syn_o != '0)));

   a_r9_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!enc_valid_o && enc_code_o == '0 && !dec_valid_o
                      && dec_data_o == '0 && dec_syn_o == '0 && !dec_fixed_o));
endmodule

bind hamming_codec hamming_codec_chk #(
   .DATA_W (DATA_W),
   .PAR_W  (PAR_W),
   .CODE_W (CODE_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .enc_valid_i (enc_valid_i),
   .enc_valid_o (enc_valid_o),
   .enc_code_o  (enc_code_o),
   .dec_valid_i (dec_valid_i),
   .dec_valid_o (dec_valid_o),
   .dec_data_o  (dec_data_o),
   .dec_syn_o   (dec_syn_o),
   .dec_fixed_o (dec_fixed_o)
);

// File: tb/sim_hamming_codec.sv
`timescale 1ns/1ps
module sim_hamming_codec;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // (15,11) instance
   logic        e0_v = 0, d0_v = 0;
   logic [10:0] e0_d = '0;
   logic [14:0] d0_c = '0;
   logic        e0_vo, d0_vo, d0_f;
   logic [14:0] e0_c;
   logic [10:0] d0_d;
   logic [3:0]  d0_s;

   // (7,4) instance
   logic        e1_v = 0, d1_v = 0;
   logic [3:0]  e1_d = '0;
   logic [6:0]  d1_c = '0;
   logic        e1_vo, d1_vo, d1_f;
   logic [6:0]  e1_c;
   logic [3:0]  d1_d;
   logic [2:0]  d1_s;

   hamming_codec #(.DATA_W(11)) u0 (
      .clk(clk), .rst(rst),
      .enc_valid_i(e0_v), .enc_data_i(e0_d), .enc_valid_o(e0_vo), .enc_code_o(e0_c),
      .dec_valid_i(d0_v), .dec_code_i(d0_c), .dec_valid_o(d0_vo), .dec_data_o(d0_d),
      .dec_syn_o(d0_s), .dec_fixed_o(d0_f));

   hamming_codec #(.DATA_W(4)) u1 (
      .clk(clk), .rst(rst),
      .enc_valid_i(e1_v), .enc_data_i(e1_d), .enc_valid_o(e1_vo), .enc_code_o(e1_c),
      .dec_valid_i(d1_v), .dec_code_i(d1_c), .dec_valid_o(d1_vo), .dec_data_o(d1_d),
      .dec_syn_o(d1_s), .dec_fixed_o(d1_f));

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // model: place data, then set each check bit from the XOR of set positions
   function automatic logic [15:0] m_enc(input logic [10:0] d, input int cw);
      logic [15:0] c;
      int k, s;
      c = '0; k = 0; s = 0;
      for (int p = 1; p <= cw; p++)
         if ((p & (p - 1)) != 0) begin c[p-1] = d[k]; k++; end
      for (int p = 1; p <= cw; p++) if (c[p-1]) s = s ^ p;
      for (int j = 0; (1 << j) <= cw; j++) c[(1 << j) - 1] = ((s >> j) & 1) == 1;
      return c;
   endfunction

   function automatic int m_syn(input logic [15:0] c, input int cw);
      int s;
      s = 0;
      for (int p = 1; p <= cw; p++) if (c[p-1]) s = s ^ p;
      return s;
   endfunction

   task automatic enc0(input logic [10:0] d, output logic [14:0] code);
      logic [15:0] exp;
      exp = m_enc(d, 15);
      @(negedge clk); e0_v = 1; e0_d = d;
      @(posedge clk); #1;
      chk(e0_vo == 1'b1, "R3 enc valid", 32'(e0_vo), 1);
      chk(e0_c == exp[14:0], "R2 codeword", 32'(e0_c), 32'(exp[14:0]));
      chk(m_syn({1'b0, e0_c}, 15) == 0, "R2 even groups", 32'(e0_c), 32'(exp[14:0]));
      code = e0_c;
      e0_v = 0;
   endtask

   task automatic dec0(input logic [14:0] code, input logic [10:0] d, input int flip);
      @(negedge clk); d0_v = 1; d0_c = code;
      @(posedge clk); #1;
      chk(d0_vo == 1'b1, "R8 dec valid", 32'(d0_vo), 1);
      chk(d0_s == 4'(flip), "R4 syndrome", 32'(d0_s), 32'(flip));
      if (flip == 0) begin
         chk(d0_d == d, "R6 clean data", 32'(d0_d), 32'(d));
         chk(d0_f == 1'b0, "R6 flag low", 32'(d0_f), 0);
      end else if ((flip & (flip - 1)) == 0) begin
         chk(d0_d == d, "R7 check-slot data", 32'(d0_d), 32'(d));
         chk(d0_f == 1'b1, "R7 flag", 32'(d0_f), 1);
      end else begin
         chk(d0_d == d, "R5 corrected data", 32'(d0_d), 32'(d));
         chk(d0_f == 1'b1, "R5 flag", 32'(d0_f), 1);
      end
      d0_v = 0;
   endtask

   task automatic enc1(input logic [3:0] d, output logic [6:0] code);
      logic [15:0] exp;
      exp = m_enc({7'd0, d}, 7);
      @(negedge clk); e1_v = 1; e1_d = d;
      @(posedge clk); #1;
      chk(e1_vo && e1_c == exp[6:0], "R10 short encode", 32'(e1_c), 32'(exp[6:0]));
      code = e1_c;
      e1_v = 0;
   endtask

   task automatic dec1(input logic [6:0] code, input logic [3:0] d, input int syn);
      @(negedge clk); d1_v = 1; d1_c = code;
      @(posedge clk); #1;
      chk(d1_vo && d1_s == 3'(syn), "R10 short syndrome", 32'(d1_s), 32'(syn));
      chk(d1_d == d, "R10 short data", 32'(d1_d), 32'(d));
      chk(d1_f == (syn != 0), "R10 short flag", 32'(d1_f), 32'(syn != 0));
      d1_v = 0;
   endtask

   initial begin
      #(4 * 190000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [14:0] c0;
      logic [6:0]  c1;
      logic [10:0] d;
      void'($urandom(32'd20190503));

      repeat (3) @(posedge clk);
      #1;
      chk(!e0_vo && e0_c == 0 && !d0_vo && d0_d == 0 && d0_s == 0 && !d0_f,
          "R9 reset state", 32'(e0_c), 0);
      @(negedge clk); rst = 0;

      // R1 layout anchors
      enc0(11'h001, c0);
      chk(c0 == 15'h0007, "R1 first data slot", 32'(c0), 32'h0007);
      enc0(11'h400, c0);
      chk(c0 == 15'h408B, "R1 last data slot", 32'(c0), 32'h408B);

      // R3 hold while idle
      @(negedge clk); e0_d = 11'h2AA;
      @(posedge clk); #1;
      chk(!e0_vo, "R3 idle strobe", 32'(e0_vo), 0);
      chk(e0_c == 15'h408B, "R3 idle hold", 32'(e0_c), 32'h408B);

      // directed and random words, every single flip
      for (int n = 0; n < 160; n++) begin
         case (n)
            0: d = 11'h000;
            1: d = 11'h7FF;
            2: d = 11'h555;
            default: d = 11'($urandom);
         endcase
         enc0(d, c0);
         for (int e = 0; e <= 15; e++) begin
            logic [14:0] bad;
            bad = c0;
            if (e != 0) bad[e-1] = ~bad[e-1];
            dec0(bad, d, e);
         end
      end

      // R8 hold while idle
      @(negedge clk); d0_c = 15'h1234;
      @(posedge clk); #1;
      chk(!d0_vo, "R8 idle strobe", 32'(d0_vo), 0);
      chk(d0_d == d && d0_s == 4'd15 && d0_f, "R8 idle hold", 32'(d0_d), 32'(d));

      // R9 mid-run reset with strobes pending
      @(negedge clk); rst = 1; e0_v = 1; d0_v = 1;
      @(posedge clk); #1;
      chk(!e0_vo && e0_c == 0 && !d0_vo && d0_d == 0 && d0_s == 0 && !d0_f,
          "R9 reset clears", 32'(d0_d), 0);
      @(negedge clk); rst = 0; e0_v = 0; d0_v = 0;

      // R10 known short vectors
      enc1(4'b0100, c1);
      chk(c1 == 7'h2A, "R10 vector encode", 32'(c1), 32'h2A);
      dec1(7'h75, 4'hB, 6);

      // R10 exhaustive short code
      for (int v = 0; v < 16; v++) begin
         enc1(4'(v), c1);
         for (int e = 0; e <= 7; e++) begin
            logic [6:0] bad;
            bad = c1;
            if (e != 0) bad[e-1] = ~bad[e-1];
            dec1(bad, 4'(v), e);
         end
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule